// File: doc/BRIEF.md
# Audio Converter Power-Up Sequencer

This block brings an audio converter from power-on to normal operation. After a system reset it holds the datapath filters, the modulators and the control registers in reset, and it keeps every power enable low. Nothing moves until the external reset pin is driven high. On that rising edge the block opens the control register path. If hardware mode is selected, it also captures the configuration pins, which then serve as the default feature settings.

The block then waits until the master clock has toggled often enough within a window of the free-running system clock. Once that happens it powers the reference and the converters and clamps the analog outputs to the quiescent level. When the frame clock is running, it counts master clock rising edges over one frame period and maps the count to a ratio code. It then waits a programmable number of frame periods and releases the clamp together with a ready flag.

A count that fits no supported ratio raises an error flag and starts a new measurement. If the master clock is lost, the block falls back to the clamped, unpowered wait state. If the frame clock is lost, it falls back to the clamped, powered wait state. A low reset pin returns it to power-down. All clock inputs are sampled in the system clock domain through synchronizers.

Top module: `codec_pwrup_seq`

## Requirements
- R1: After the system reset, the block is in power-down: dp_rst=1, ctl_en=0, ref_en=0, conv_en=0, clamp=1, ready=0.
- R2: While rst_pin_n is low, the block stays in power-down even when both clocks are running.
- R3: Once rst_pin_n is high, dp_rst goes to 0 and ctl_en goes to 1 within a few cycles.
- R4: On the synchronized rising edge of rst_pin_n, cfg_q takes cfg_pins if hw_mode=1 and takes all zeros if hw_mode=0. Later changes of cfg_pins do not change cfg_q.
- R5: The master clock counts as valid when MCLK_MIN_TOG or more rising edges fall within a window of MCLK_WIN system cycles. When it is valid, ref_en=1 and conv_en=1, while clamp stays 1.
- R6: The ratio is the number of master clock rising edges between two consecutive frame clock rising edges. The ratio code is 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512, 5 for 768 and 6 for 1024. A count within ±RATIO_TOL (2) of a supported value selects that value's code.
- R7: Ready rises, and clamp falls, only after DELAY_FRAMES frame clock rising edges have followed a valid measurement. Clamp is always the inverse of ready.
- R8: A count outside every tolerance band sets ratio_err=1, keeps ready=0 and starts a new measurement. The next valid measurement clears ratio_err.
- R9: If the master clock stops, ready drops, clamp returns to 1 and ref_en and conv_en drop. The sequence restarts when the clock returns.
- R10: If no frame clock edge arrives within LRCK_TMO cycles, ready drops and clamp returns to 1, while ref_en and conv_en stay 1.
- R11: A low rst_pin_n returns the block to the power-down state of R1 from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high system reset |
| mclk_in | input | 1 | Master clock, sampled asynchronously |
| lrck_in | input | 1 | Frame clock, sampled asynchronously |
| rst_pin_n | input | 1 | External reset pin; low holds power-down |
| hw_mode | input | 1 | Selects capture of the configuration pins |
| cfg_pins | input | CFG_W | Configuration pins |
| dp_rst | output | 1 | Reset for the datapath and control registers |
| ctl_en | output | 1 | Control register interface enable |
| ref_en | output | 1 | Reference power-up enable |
| conv_en | output | 1 | Converter and filter power enable |
| clamp | output | 1 | Holds the analog outputs at the quiescent level |
| ratio_code | output | 3 | Detected master-to-frame clock ratio code |
| ready | output | 1 | Normal operation |
| ratio_err | output | 1 | Last measurement matched no supported ratio |
| cfg_q | output | CFG_W | Captured configuration |

## Verification
The hardest conditions to reach are the edges of each tolerance band and a clock that stops after ready is up. The frame clock generator in the bench is set to any whole count of master clock periods per frame. Directed runs place the count two inside a band and three outside one, and random runs choose a supported ratio plus an offset of up to two. A running sequence reaches a clock loss by freezing one of the generated clocks while the other keeps running. The bench then lets the same generator resume and checks that the sequence recovers.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_MCLK,
    ST_WAIT_LRCK,
    ST_MEASURE,
    ST_SETTLE,
    ST_RUN
  } seq_state_t;

  localparam int unsigned NUM_RATIOS = 7;
  localparam int unsigned CODE_W     = 3;

  // Supported ratios alternate between powers of two from 128 and 1.5x those.
  function automatic int unsigned nominal_ratio(input int unsigned idx);
    return ((idx % 2) == 0) ? (32'd128 << (idx / 2)) : (32'd192 << (idx / 2));
  endfunction
endpackage

// File: rtl/cps_sync.sv
`timescale 1ns/1ps
module cps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cps_clk_mon.sv
`timescale 1ns/1ps
module cps_clk_mon #(
  parameter int MCLK_WIN     = 64,
  parameter int MCLK_MIN_TOG = 8,
  parameter int LRCK_TMO     = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_rise,
  input  logic lrck_rise,
  output logic mclk_ok,
  output logic lrck_ok
);
  localparam int WIN_W = $clog2(MCLK_WIN);
  localparam int TOG_W = $clog2(MCLK_MIN_TOG + 1);
  localparam int TMO_W = $clog2(LRCK_TMO + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(MCLK_WIN - 1);
  localparam logic [TOG_W-1:0] TOG_SAT  = TOG_W'(MCLK_MIN_TOG);
  localparam logic [TMO_W-1:0] TMO_END  = TMO_W'(LRCK_TMO);

  logic [WIN_W-1:0] win_cnt;
  logic [TOG_W-1:0] tog_cnt;
  logic [TOG_W-1:0] tog_next;
  logic [TMO_W-1:0] tmr;
  logic             seen_edge;

  assign tog_next = (mclk_rise && (tog_cnt != TOG_SAT)) ? tog_cnt + 1'b1 : tog_cnt;

  // Master clock activity is judged once per window.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      tog_cnt <= '0;
      mclk_ok <= 1'b0;
    end else if (win_cnt == WIN_LAST) begin
      win_cnt <= '0;
      tog_cnt <= '0;
      mclk_ok <= (tog_next == TOG_SAT);
    end else begin
      win_cnt <= win_cnt + 1'b1;
      tog_cnt <= tog_next;
    end
  end

  // Frame clock is valid after two rising edges closer than the timeout.
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr       <= '0;
      seen_edge <= 1'b0;
      lrck_ok   <= 1'b0;
    end else if (lrck_rise) begin
      tmr       <= '0;
      seen_edge <= 1'b1;
      lrck_ok   <= seen_edge;
    end else if (tmr == TMO_END) begin
      seen_edge <= 1'b0;
      lrck_ok   <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/cps_ratio_meter.sv
`timescale 1ns/1ps
module cps_ratio_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             mclk_rise,
  input  logic             lrck_rise,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             started;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      started <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
      count   <= '0;
    end else begin
      done <= 1'b0;
      if (lrck_rise) begin
        if (started) begin
          done  <= 1'b1;
          count <= cnt;
        end
        started <= 1'b1;
        cnt     <= mclk_rise ? CNT_W'(1) : '0;
      end else if (mclk_rise && (cnt != CNT_MAX)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cps_ratio_decode.sv
`timescale 1ns/1ps
module cps_ratio_decode
  import cps_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0]  count,
  output logic              hit,
  output logic [CODE_W-1:0] code
);
  localparam int EXT_W = CNT_W + 2;

  logic [NUM_RATIOS-1:0] match;
  logic [EXT_W-1:0]      cnt_ext;

  assign cnt_ext = {2'b00, count};

  generate
    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_band
      localparam logic [EXT_W-1:0] LO = EXT_W'(nominal_ratio(i) - TOL);
      localparam logic [EXT_W-1:0] HI = EXT_W'(nominal_ratio(i) + TOL);
      assign match[i] = (cnt_ext >= LO) && (cnt_ext <= HI);
    end
  endgenerate

  always_comb begin
    hit  = |match;
    code = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (match[i]) code = CODE_W'(i);
    end
  end
endmodule

// File: rtl/codec_pwrup_seq.sv
`timescale 1ns/1ps
module codec_pwrup_seq
  import cps_pkg::*;
#(
  parameter int CFG_W        = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int MCLK_WIN     = 64,
  parameter int MCLK_MIN_TOG = 8,
  parameter int LRCK_TMO     = 8192,
  parameter int CNT_W        = 12,
  parameter int RATIO_TOL    = 2,
  parameter int DELAY_FRAMES = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk_in,
  input  logic             lrck_in,
  input  logic             rst_pin_n,
  input  logic             hw_mode,
  input  logic [CFG_W-1:0] cfg_pins,
  output logic             dp_rst,
  output logic             ctl_en,
  output logic             ref_en,
  output logic             conv_en,
  output logic             clamp,
  output logic [2:0]       ratio_code,
  output logic             ready,
  output logic             ratio_err,
  output logic [CFG_W-1:0] cfg_q
);
  localparam int FRM_W = $clog2(DELAY_FRAMES + 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(DELAY_FRAMES - 1);

  logic [2:0]        sync_q;
  logic [2:0]        prev_q;
  logic              pin_s, pin_rise, mclk_rise, lrck_rise;
  logic              mclk_ok, lrck_ok;
  logic              meas_done, hit;
  logic [CNT_W-1:0]  meas_cnt;
  logic [CODE_W-1:0] hit_code;
  logic [FRM_W-1:0]  frm_cnt;
  seq_state_t        state, nxt;

  cps_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rst_pin_n, lrck_in, mclk_in}),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_q;
  end

  assign pin_s     = sync_q[2];
  assign pin_rise  = sync_q[2] & ~prev_q[2];
  assign lrck_rise = sync_q[1] & ~prev_q[1];
  assign mclk_rise = sync_q[0] & ~prev_q[0];

  cps_clk_mon #(
    .MCLK_WIN     (MCLK_WIN),
    .MCLK_MIN_TOG (MCLK_MIN_TOG),
    .LRCK_TMO     (LRCK_TMO)
  ) u_mon (
    .clk       (clk),
    .rst       (rst),
    .mclk_rise (mclk_rise),
    .lrck_rise (lrck_rise),
    .mclk_ok   (mclk_ok),
    .lrck_ok   (lrck_ok)
  );

  cps_ratio_meter #(.CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .arm       (state == ST_MEASURE),
    .mclk_rise (mclk_rise),
    .lrck_rise (lrck_rise),
    .done      (meas_done),
    .count     (meas_cnt)
  );

  cps_ratio_decode #(.CNT_W(CNT_W), .TOL(RATIO_TOL)) u_decode (
    .count (meas_cnt),
    .hit   (hit),
    .code  (hit_code)
  );

  always_comb begin
    nxt = state;
    if (!pin_s) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:       nxt = ST_WAIT_MCLK;
        ST_WAIT_MCLK: if (mclk_ok) nxt = ST_WAIT_LRCK;
        ST_WAIT_LRCK: begin
          if (!mclk_ok)     nxt = ST_WAIT_MCLK;
          else if (lrck_ok) nxt = ST_MEASURE;
        end
        ST_MEASURE: begin
          if (!mclk_ok)                nxt = ST_WAIT_MCLK;
          else if (!lrck_ok)           nxt = ST_WAIT_LRCK;
          else if (meas_done && hit)   nxt = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (!mclk_ok)                            nxt = ST_WAIT_MCLK;
          else if (!lrck_ok)                       nxt = ST_WAIT_LRCK;
          else if (lrck_rise && frm_cnt == FRM_LAST) nxt = ST_RUN;
        end
        ST_RUN: begin
          if (!mclk_ok)      nxt = ST_WAIT_MCLK;
          else if (!lrck_ok) nxt = ST_WAIT_LRCK;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      dp_rst     <= 1'b1;
      ctl_en     <= 1'b0;
      ref_en     <= 1'b0;
      conv_en    <= 1'b0;
      clamp      <= 1'b1;
      ready      <= 1'b0;
      ratio_code <= '0;
      ratio_err  <= 1'b0;
      cfg_q      <= '0;
      frm_cnt    <= '0;
    end else begin
      state   <= nxt;
      dp_rst  <= (nxt == ST_OFF);
      ctl_en  <= (nxt != ST_OFF);
      ref_en  <= (nxt inside {ST_WAIT_LRCK, ST_MEASURE, ST_SETTLE, ST_RUN});
      conv_en <= (nxt inside {ST_WAIT_LRCK, ST_MEASURE, ST_SETTLE, ST_RUN});
      clamp   <= (nxt != ST_RUN);
      ready   <= (nxt == ST_RUN);

      if (pin_rise) cfg_q <= hw_mode ? cfg_pins : '0;

      if (nxt == ST_OFF) begin
        ratio_code <= '0;
        ratio_err  <= 1'b0;
      end else if (state == ST_MEASURE && meas_done) begin
        if (hit) begin
          ratio_code <= hit_code;
          ratio_err  <= 1'b0;
        end else begin
          ratio_err  <= 1'b1;
        end
      end

      if (state != ST_SETTLE) frm_cnt <= '0;
      else if (lrck_rise)     frm_cnt <= frm_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cps_checker.sv
`timescale 1ns/1ps
module cps_checker #(
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_pin_n,
  input logic             dp_rst,
  input logic             ctl_en,
  input logic             ref_en,
  input logic             conv_en,
  input logic             clamp,
  input logic             ready,
  input logic             ratio_err,
  input logic [2:0]       ratio_code,
  input logic [CFG_W-1:0] cfg_q,
  input logic             mclk_ok,
  input logic             lrck_ok
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    dp_rst |-> (!ctl_en && !ref_en && !conv_en && clamp && !ready));

  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!dp_rst && $past(!dp_rst)) |-> $stable(cfg_q));

  assert_ready_powered_R5: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ref_en && conv_en));

  assert_code_range_R6: assert property (@(posedge clk) disable iff (rst)
    ratio_code < 3'd7);

  assert_clamp_inverse_R7: assert property (@(posedge clk) disable iff (rst)
    clamp != ready);

  assert_err_blocks_ready_R8: assert property (@(posedge clk) disable iff (rst)
    ratio_err |-> !ready);

  assert_mclk_loss_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!mclk_ok) |-> (!conv_en && !ref_en && !ready));

  assert_lrck_loss_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!lrck_ok) |-> !ready);

  assert_pin_low_R11: assert property (@(posedge clk) disable iff (rst)
    (!rst_pin_n && $past(!rst_pin_n) && $past(!rst_pin_n, 2) && $past(!rst_pin_n, 3)) |-> dp_rst);
endmodule

bind codec_pwrup_seq cps_checker #(.CFG_W(CFG_W)) u_cps_checker (
  .clk        (clk),
  .rst        (rst),
  .rst_pin_n  (rst_pin_n),
  .dp_rst     (dp_rst),
  .ctl_en     (ctl_en),
  .ref_en     (ref_en),
  .conv_en    (conv_en),
  .clamp      (clamp),
  .ready      (ready),
  .ratio_err  (ratio_err),
  .ratio_code (ratio_code),
  .cfg_q      (cfg_q),
  .mclk_ok    (mclk_ok),
  .lrck_ok    (lrck_ok)
);

// File: tb/test_codec_pwrup_seq.sv
`timescale 1ns/1ps
module test_codec_pwrup_seq;
  localparam int CFG_W    = 4;
  localparam int WIN      = 64;
  localparam int TMO      = 4500;
  localparam int DELAY    = 3;
  localparam int NOMS [7] = '{128, 192, 256, 384, 512, 768, 1024};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mclk_in = 1'b0;
  logic             lrck_in = 1'b0;
  logic             rst_pin_n = 1'b0;
  logic             hw_mode = 1'b0;
  logic [CFG_W-1:0] cfg_pins = '0;
  logic             dp_rst, ctl_en, ref_en, conv_en, clamp, ready, ratio_err;
  logic [2:0]       ratio_code;
  logic [CFG_W-1:0] cfg_q;

  int  checks = 0;
  int  errors = 0;
  int  gen_ratio = 256;
  bit  mclk_on = 1'b0;
  bit  lrck_on = 1'b0;
  int  ph = 0;
  int  rise_total = 0;
  logic lrck_prev = 1'b0;

  always #2.5 clk = ~clk;

  codec_pwrup_seq #(
    .CFG_W        (CFG_W),
    .MCLK_WIN     (WIN),
    .MCLK_MIN_TOG (8),
    .LRCK_TMO     (TMO),
    .CNT_W        (12),
    .RATIO_TOL    (2),
    .DELAY_FRAMES (DELAY)
  ) i_codec_pwrup_seq (
    .clk        (clk),
    .rst        (rst),
    .mclk_in    (mclk_in),
    .lrck_in    (lrck_in),
    .rst_pin_n  (rst_pin_n),
    .hw_mode    (hw_mode),
    .cfg_pins   (cfg_pins),
    .dp_rst     (dp_rst),
    .ctl_en     (ctl_en),
    .ref_en     (ref_en),
    .conv_en    (conv_en),
    .clamp      (clamp),
    .ratio_code (ratio_code),
    .ready      (ready),
    .ratio_err  (ratio_err),
    .cfg_q      (cfg_q)
  );

  // Clock generator: one master period is two system cycles, frame = gen_ratio master periods.
  initial begin
    forever begin
      @(negedge clk);
      ph = (ph + 1) % (2 * gen_ratio);
      if (mclk_on) mclk_in = ph[0];
      if (lrck_on) lrck_in = (ph < gen_ratio);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (lrck_in && !lrck_prev) rise_total++;
      lrck_prev = lrck_in;
    end
  end

  function automatic int exp_code(input int n);
    exp_code = -1;
    for (int i = 0; i < 7; i++) begin
      if (n >= NOMS[i] - 2 && n <= NOMS[i] + 2) exp_code = i;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(input int max_cyc, output bit got);
    got = 1'b0;
    for (int n = 0; n < max_cyc; n++) begin
      @(negedge clk);
      if (ready) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic run_to_ready(input int exp);
    bit got;
    int r0;
    int rises;
    got = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (conv_en) begin
        got = 1'b1;
        break;
      end
    end
    chk(got && ref_en, "R5 power enables after master clock", int'(conv_en), 1);
    chk(clamp == 1'b1 && ready == 1'b0, "R5 clamp held while powering", int'(clamp), 1);
    r0 = rise_total;
    wait_ready(40000, got);
    rises = rise_total - r0;
    chk(got, "R7 ready reached", int'(ready), 1);
    chk(rises >= DELAY + 1 && rises <= DELAY + 6, "R7 frame edges before ready", rises, DELAY + 3);
    chk(int'(ratio_code) == exp, "R6 ratio code", int'(ratio_code), exp);
    chk(clamp == 1'b0 && ratio_err == 1'b0, "R7 clamp released with ready", int'(clamp), 0);
  endtask

  task automatic pin_cycle(input int ratio, input bit hw, input logic [CFG_W-1:0] cfg);
    rst_pin_n = 1'b0;
    cycles(8);
    chk(dp_rst && !ready && !conv_en && !ctl_en, "R11 pin low returns to power-down", int'(dp_rst), 1);
    gen_ratio = ratio;
    hw_mode   = hw;
    cfg_pins  = cfg;
    cycles(4);
    rst_pin_n = 1'b1;
    cycles(8);
    cfg_pins  = ~cfg;
    cycles(2);
    chk(cfg_q == (hw ? cfg : '0), "R4 configuration capture", int'(cfg_q), int'(hw ? cfg : '0));
    chk(!dp_rst && ctl_en, "R3 control path opened", int'(ctl_en), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    int n;
    void'($urandom(32'd424242));
    cycles(6);
    rst = 1'b0;
    cycles(2);
    chk(dp_rst && !ctl_en && !ref_en && !conv_en && clamp && !ready, "R1 reset state", int'(dp_rst), 1);

    // R2: clocks run, pin still low
    gen_ratio = 256;
    mclk_on = 1'b1;
    lrck_on = 1'b1;
    cycles(3000);
    chk(dp_rst && !conv_en && !ref_en && !ctl_en, "R2 held in power-down", int'(conv_en), 0);

    // Directed first start with hardware capture
    hw_mode   = 1'b1;
    cfg_pins  = 4'hA;
    rst_pin_n = 1'b1;
    cycles(8);
    cfg_pins = 4'h5;
    cycles(2);
    chk(cfg_q == 4'hA, "R4 pins captured at release", int'(cfg_q), 10);
    chk(!dp_rst && ctl_en, "R3 reset released", int'(dp_rst), 0);
    run_to_ready(2);

    // Tolerance boundaries
    pin_cycle(1022, 1'b1, 4'h3);
    run_to_ready(6);
    pin_cycle(130, 1'b0, 4'hF);
    run_to_ready(0);

    // Random supported ratios with offsets
    for (int k = 0; k < 4; k++) begin
      n = NOMS[$urandom % 7] + int'($urandom % 5) - 2;
      pin_cycle(n, 1'($urandom % 2), CFG_W'($urandom));
      run_to_ready(exp_code(n));
    end

    // R8: just outside a band
    pin_cycle(253, 1'b1, 4'h6);
    cycles(20 * 253);
    chk(ratio_err == 1'b1, "R8 error flag on unmatched ratio", int'(ratio_err), 1);
    chk(!ready && clamp && conv_en, "R8 no ready while unmatched", int'(ready), 0);
    gen_ratio = 384;
    wait_ready(20000, got);
    chk(got && ratio_err == 1'b0, "R8 recovery clears error", int'(ratio_err), 0);
    chk(int'(ratio_code) == 3, "R6 code after recovery", int'(ratio_code), 3);

    // R9: master clock lost
    mclk_on = 1'b0;
    cycles(3 * WIN + 10);
    chk(!ready && clamp && !conv_en && !ref_en, "R9 master clock loss", int'(conv_en), 0);
    mclk_on = 1'b1;
    wait_ready(20000, got);
    chk(got && int'(ratio_code) == 3, "R9 restart after master clock returns", int'(ready), 1);

    // R10: frame clock lost
    lrck_on = 1'b0;
    cycles(TMO + 50);
    chk(!ready && clamp, "R10 frame clock loss drops ready", int'(ready), 0);
    chk(conv_en && ref_en, "R10 power kept during frame clock loss", int'(conv_en), 1);
    lrck_on = 1'b1;
    wait_ready(20000, got);
    chk(got, "R10 restart after frame clock returns", int'(ready), 1);

    // R11 final power-down from running
    rst_pin_n = 1'b0;
    cycles(6);
    chk(dp_rst && !ready && clamp && !ref_en && !ctl_en, "R11 power-down from run", int'(dp_rst), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule